// File: doc/BRIEF.md
# I2C Bus Condition Qualifier

This block watches the clock and data lines of an I2C bus and reports START and STOP conditions that meet minimum timing margins. Both lines are brought into the system clock domain by a two-stage synchronizer. A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. A transition is accepted only when three margins all exceed their minimums: the time the clock line has been high, the data setup time measured from the clock rising, and the data hold time measured up to the clock falling. A transition that misses any margin is dropped without effect.

The block keeps a bus-busy level. It sets after an accepted START and clears after an accepted STOP, each after a fixed delay that depends on the speed mode. If an accepted STOP arrives while the owning controller is in slave mode, the block raises a one-cycle interrupt request. Two speed modes are selectable, standard and high-speed, and each has its own thresholds. Byte transfer, addressing, arbitration and clock generation happen elsewhere.

Top module: `i2c_cond_detect`

## Requirements
- R1: Data falling while the clock is high, with all margins met, gives exactly one cycle of `start_det_o` high.
- R2: Data rising while the clock is high, with all margins met, gives exactly one cycle of `stop_det_o` high. `start_det_o` and `stop_det_o` are never high in the same cycle.
- R3: Standard mode, setup: the data edge must come at least 14 cycles after the clock rising edge, counted at the pins (14 is accepted, 13 is rejected). The clock high time must also exceed 26 cycles, which any transition meeting both setup and hold already does.
- R4: Standard mode, hold: the clock must stay high at least 14 cycles after the data edge (14 is accepted, 13 is rejected).
- R5: High-speed mode (`hs_mode_i`=1): setup and hold each need at least 3 cycles (3 is accepted, 2 is rejected). The clock high time must exceed 4 cycles.
- R6: Standard mode: `bb_o` rises exactly 12 cycles after the `start_det_o` pulse and falls exactly 12 cycles after the `stop_det_o` pulse.
- R7: High-speed mode: the same `bb_o` delay is 6 cycles.
- R8: `irq_o` pulses in the same cycle as `stop_det_o` when `master_i` is 0. It stays low for an accepted STOP when `master_i` is 1, and it never pulses for a START.
- R9: A transition that fails any margin produces no pulse and leaves `bb_o` unchanged.
- R10: An accepted condition that arrives while a `bb_o` update is still pending replaces that update and restarts the delay. `bb_o` then follows only the newest condition.
- R11: While reset is asserted and after its release with idle lines, `bb_o`, `start_det_o`, `stop_det_o` and `irq_o` are 0.
- R12: Data transitions while the clock is low are never reported as conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line (asynchronous) |
| hs_mode_i | input | 1 | 1 selects high-speed thresholds, 0 selects standard |
| master_i | input | 1 | 1 = master mode; 0 = slave mode, which enables the STOP interrupt |
| start_det_o | output | 1 | One-cycle pulse for an accepted START |
| stop_det_o | output | 1 | One-cycle pulse for an accepted STOP |
| bb_o | output | 1 | Bus-busy level |
| irq_o | output | 1 | One-cycle interrupt request for a STOP seen in slave mode |

## Verification
There are two coincidences to cover. The first is the interrupt and the STOP pulse, which must land in the same cycle; a monitor flags any `irq_o` cycle without `stop_det_o`. The second is a new accepted condition arriving while a busy-flag update is still counting down. The bench provokes this in high-speed mode by placing a STOP 4 cycles after an accepted START, which is inside the 6-cycle delay. It then checks that both pulses appear and that `bb_o` never rises.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_START = 2'd1,
    EV_STOP  = 2'd2
  } bus_ev_e;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[g] <= RST_VAL;
      else if (g == 0) stg[g] <= d_i;
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/cond_qual.sv
module cond_qual
  import i2c_cond_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int STD_REL = 26,
  parameter int STD_SU  = 13,
  parameter int STD_HD  = 13,
  parameter int HS_REL  = 4,
  parameter int HS_SU   = 2,
  parameter int HS_HD   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic hs_i,
  input  logic master_i,
  output logic start_o,
  output logic stop_o,
  output logic irq_o
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] rel_min, su_min, hd_min;
  logic             scl_p, sda_p;
  logic [CNT_W-1:0] hi_cnt, hold_cnt;
  logic             pend;
  bus_ev_e          kind;
  logic             sda_edge, fire;

  // strict '>' for release/setup; hold counted as cycles since edge
  assign rel_min = hs_i ? CNT_W'(HS_REL) : CNT_W'(STD_REL);
  assign su_min  = hs_i ? CNT_W'(HS_SU)  : CNT_W'(STD_SU);
  assign hd_min  = hs_i ? CNT_W'(HS_HD)  : CNT_W'(STD_HD);

  assign sda_edge = scl_i && scl_p && (sda_i != sda_p);
  assign fire     = pend && scl_i && !sda_edge &&
                    (hold_cnt >= hd_min) && (hi_cnt > rel_min);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
      hi_cnt   <= '0;
      hold_cnt <= '0;
      pend     <= 1'b0;
      kind     <= EV_NONE;
    end else begin
      scl_p <= scl_i;
      sda_p <= sda_i;
      if (!scl_i)              hi_cnt <= '0;
      else if (hi_cnt != CMAX) hi_cnt <= hi_cnt + 1'b1;

      if (!scl_i) begin
        pend <= 1'b0;
      end else if (sda_edge) begin
        pend     <= (hi_cnt > su_min);
        kind     <= sda_i ? EV_STOP : EV_START;
        hold_cnt <= CNT_W'(1);
      end else if (fire) begin
        pend <= 1'b0;
      end else if (pend && hold_cnt != CMAX) begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      start_o <= fire && (kind == EV_START);
      stop_o  <= fire && (kind == EV_STOP);
      irq_o   <= fire && (kind == EV_STOP) && !master_i;
    end
  end

endmodule

// File: rtl/busy_track.sv
module busy_track #(
  parameter int STD_DLY = 12,
  parameter int HS_DLY  = 6,
  parameter int DW      = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic hs_i,
  output logic bb_o
);

  logic [DW-1:0] cnt;
  logic          nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt  <= '0;
      nxt  <= 1'b0;
      bb_o <= 1'b0;
    end else if (start_i || stop_i) begin
      cnt <= hs_i ? DW'(HS_DLY - 1) : DW'(STD_DLY - 1);
      nxt <= start_i;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == DW'(1)) bb_o <= nxt;
    end
  end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect #(
  parameter int STD_REL = 26,
  parameter int STD_SU  = 13,
  parameter int STD_HD  = 13,
  parameter int STD_BB  = 12,
  parameter int HS_REL  = 4,
  parameter int HS_SU   = 2,
  parameter int HS_HD   = 2,
  parameter int HS_BB   = 6,
  parameter int SYNC_N  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic hs_mode_i,
  input  logic master_i,
  output logic start_det_o,
  output logic stop_det_o,
  output logic bb_o,
  output logic irq_o
);

  localparam int CNT_W = $clog2(STD_REL + STD_SU + STD_HD + HS_REL + 4);
  localparam int DW    = $clog2(STD_BB + HS_BB + 2);

  logic [1:0] line_s;

  line_sync #(.W(2), .STAGES(SYNC_N), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  cond_qual #(
    .CNT_W(CNT_W), .STD_REL(STD_REL), .STD_SU(STD_SU), .STD_HD(STD_HD),
    .HS_REL(HS_REL), .HS_SU(HS_SU), .HS_HD(HS_HD)
  ) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (line_s[1]),
    .sda_i   (line_s[0]),
    .hs_i    (hs_mode_i),
    .master_i(master_i),
    .start_o (start_det_o),
    .stop_o  (stop_det_o),
    .irq_o   (irq_o)
  );

  busy_track #(.STD_DLY(STD_BB), .HS_DLY(HS_BB), .DW(DW)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_det_o),
    .stop_i (stop_det_o),
    .hs_i   (hs_mode_i),
    .bb_o   (bb_o)
  );

endmodule

// File: rtl/cond_chk.sv
module cond_chk #(
  parameter int STD_BB = 12,
  parameter int HS_BB  = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hs_mode_i,
  input logic master_i,
  input logic start_det_o,
  input logic stop_det_o,
  input logic bb_o,
  input logic irq_o
);

  localparam int SW = $clog2(STD_BB + HS_BB + 4);
  localparam logic [SW-1:0] SMAX = '1;

  logic [SW-1:0] since, dly;
  logic          last_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since      <= '0;
      dly        <= '0;
      last_start <= 1'b0;
    end else if (start_det_o || stop_det_o) begin
      since      <= SW'(1);
      dly        <= hs_mode_i ? SW'(HS_BB) : SW'(STD_BB);
      last_start <= start_det_o;
    end else if (since != SMAX && since != '0) begin
      since <= since + 1'b1;
    end
  end

  AST_DET_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_det_o && stop_det_o));                                      // R2
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det_o |=> !start_det_o);                                      // R1
  AST_STOP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_o |=> !stop_det_o);                                        // R2
  AST_IRQ_SLAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stop_det_o && !$past(master_i)));                        // R8
  AST_BB_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bb_o) |-> (since == dly));                                 // R6
  AST_BB_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bb_o) |-> (bb_o == last_start));                           // R10

endmodule

bind i2c_cond_detect cond_chk #(.STD_BB(STD_BB), .HS_BB(HS_BB)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hs_mode_i  (hs_mode_i),
  .master_i   (master_i),
  .start_det_o(start_det_o),
  .stop_det_o (stop_det_o),
  .bb_o       (bb_o),
  .irq_o      (irq_o)
);

// File: tb/tb_i2c_cond_detect.sv
module tb_i2c_cond_detect;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, hs = 1'b0, mst = 1'b0;
  logic start_det, stop_det, bb, irq;

  int checks = 0, errors = 0;
  int n_start = 0, n_stop = 0, n_irq = 0, n_irq_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_cond_detect dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .hs_mode_i(hs), .master_i(mst),
    .start_det_o(start_det), .stop_det_o(stop_det), .bb_o(bb), .irq_o(irq)
  );

  always @(negedge clk) if (rst_n) begin
    if (start_det) n_start++;
    if (stop_det)  n_stop++;
    if (irq)       n_irq++;
    if (irq && !stop_det) n_irq_bad++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_bb(input bit exp, input string req);
    chk(bb == exp, req, "bb level", int'(bb), int'(exp));
  endtask

  // full condition with given setup and hold, counted at the pins
  task automatic run_cond(input bit is_start, input int su, input int hd,
                          input bit exp_acc, input string req);
    int s0 = n_start, p0 = n_stop, i0 = n_irq;
    scl = 1'b0; cyc(3);
    sda = is_start; cyc(3);
    scl = 1'b1; cyc(su);
    sda = !is_start; cyc(hd);
    scl = 1'b0; cyc(3);
    sda = 1'b1; cyc(2);
    scl = 1'b1; cyc(25);
    chk(n_start - s0 == int'(exp_acc && is_start), req, "start pulses",
        n_start - s0, int'(exp_acc && is_start));
    chk(n_stop - p0 == int'(exp_acc && !is_start), req, "stop pulses",
        n_stop - p0, int'(exp_acc && !is_start));
    chk(n_irq - i0 == int'(exp_acc && !is_start && !mst), "R8", "irq pulses",
        n_irq - i0, int'(exp_acc && !is_start && !mst));
  endtask

  // measures cycles from detect pulse to bb change
  task automatic timed_cond(input bit is_start, input int exp_d, input string req);
    int p = -1, b = -1;
    logic prev;
    scl = 1'b0; cyc(3);
    sda = is_start; cyc(3);
    scl = 1'b1; cyc(20);
    prev = bb;
    sda = !is_start;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if ((is_start ? start_det : stop_det) && p < 0) p = i;
      if (bb != prev && b < 0) b = i;
    end
    chk(p >= 0, req, "detect pulse seen", p, 0);
    chk(b - p == exp_d, req, "bb delay", b - p, exp_d);
    chk(bb == is_start, req, "bb final", int'(bb), int'(is_start));
    scl = 1'b0; cyc(3);
    sda = 1'b1; cyc(2);
    scl = 1'b1; cyc(10);
  endtask

  task automatic t_reset;
    cyc(3);
    chk(!bb && !start_det && !stop_det && !irq, "R11", "outputs in reset",
        {bb, start_det, stop_det, irq}, 0);
    rst_n = 1'b1;
    cyc(40);
    chk(!bb && n_start == 0 && n_stop == 0 && n_irq == 0, "R11",
        "idle after reset", {bb, 3'b0} | (n_start + n_stop + n_irq), 0);
  endtask

  task automatic t_std;
    hs = 1'b0; mst = 1'b0;
    timed_cond(1'b1, 12, "R6");
    timed_cond(1'b0, 12, "R6");
    run_cond(1'b1, 14, 20, 1'b1, "R3"); check_bb(1'b1, "R1");
    run_cond(1'b0, 13, 20, 1'b0, "R3"); check_bb(1'b1, "R9");
    run_cond(1'b0, 20, 13, 1'b0, "R4"); check_bb(1'b1, "R9");
    run_cond(1'b0, 20, 14, 1'b1, "R4"); check_bb(1'b0, "R2");
    run_cond(1'b1, 20, 13, 1'b0, "R4"); check_bb(1'b0, "R9");
  endtask

  task automatic t_master;
    mst = 1'b1;
    run_cond(1'b1, 20, 20, 1'b1, "R1");
    run_cond(1'b0, 20, 20, 1'b1, "R8");
    check_bb(1'b0, "R2");
    mst = 1'b0;
  endtask

  task automatic t_data_low;
    int s0 = n_start, p0 = n_stop;
    scl = 1'b0; cyc(3);
    for (int i = 0; i < 8; i++) begin sda = ~sda; cyc(5); end
    sda = 1'b1; cyc(2);
    scl = 1'b1; cyc(25);
    chk(n_start == s0 && n_stop == p0, "R12", "pulses from data with clock low",
        (n_start - s0) + (n_stop - p0), 0);
    check_bb(1'b0, "R12");
  endtask

  task automatic t_hs;
    hs = 1'b1; cyc(5);
    run_cond(1'b1, 2, 5, 1'b0, "R5");  check_bb(1'b0, "R9");
    run_cond(1'b1, 3, 3, 1'b1, "R5");  check_bb(1'b1, "R5");
    run_cond(1'b0, 5, 2, 1'b0, "R5");  check_bb(1'b1, "R9");
    run_cond(1'b0, 3, 3, 1'b1, "R5");  check_bb(1'b0, "R5");
    timed_cond(1'b1, 6, "R7");
    timed_cond(1'b0, 6, "R7");
  endtask

  // START then STOP 4 cycles apart, inside the 6-cycle busy delay
  task automatic t_restart;
    int ps = -1, pp = -1;
    bit rose = 1'b0;
    hs = 1'b1;
    scl = 1'b0; cyc(3);
    sda = 1'b1; cyc(3);
    scl = 1'b1; cyc(5);
    sda = 1'b0; cyc(4);
    sda = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (start_det && ps < 0) ps = i;
      if (stop_det && pp < 0) pp = i;
      if (bb) rose = 1'b1;
    end
    chk(ps >= 0 && pp >= 0, "R10", "both pulses seen", int'(ps >= 0 && pp >= 0), 1);
    chk(!rose, "R10", "bb stayed low after superseded start", int'(rose), 0);
    chk(n_irq_bad == 0, "R8", "irq without stop pulse", n_irq_bad, 0);
    hs = 1'b0; cyc(5);
  endtask

  initial begin
    t_reset();
    t_std();
    t_master();
    t_data_low();
    t_hs();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule